// File: doc/BRIEF.md
# Instruction-Cycle Time Base with Overflow Latch and Idle

This block is the time base of a small processor core. An 8-bit counter advances by one on every enabled instruction cycle and runs freely. When it wraps from all ones to zero it sets a sticky overflow latch. Software can poll this latch to build its own real-time tick without any external input.

The core drives three instruction strobes, and each acts only in a cycle where the cycle enable is high. The test strobe reports the latch on the skip output in the same cycle and clears the latch. The load strobe writes a new counter value. The idle strobe stops the core: the halt output gates every other part of the core, and it falls again once the counter overflows. While halt is high, only the counter keeps moving.

Top module: `tbase_timer`

## Requirements
- R1: After reset the counter is zero and both the latch and halt are clear, so a test issued straight after reset gives no skip and halt reads 0.
- R2: The counter advances by one on each cycle with cyc_en high and holds when cyc_en is low. A step from 0xFF to 0x00 sets the latch.
- R3: A test strobe while the latch is clear leaves skip_req at 0 and keeps the latch clear.
- R4: A test strobe while the latch is set drives skip_req high in that same cycle and clears the latch, so an immediate second test gives no skip.
- R5: A load strobe replaces the counter with load_val in place of that cycle's increment. If bit 7 of load_val is 1, the load also sets the latch.
- R6: A load whose bit 7 is 0 leaves the latch as it was.
- R7: If a wrap and a latch-clearing test fall in the same cycle, the latch ends that cycle set.
- R8: An idle strobe raises halt from the next cycle. The counter keeps advancing while halt is high, and halt falls in the cycle after the wrap.
- R9: While halt is high, load, test and idle strobes have no effect, and skip_req stays 0.
- R10: With cyc_en low, no strobe has any effect and skip_req stays 0.
- R11: An idle strobe issued in the cycle in which the counter wraps does not raise halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | input | 1 | High for one clock per instruction cycle |
| load_stb | input | 1 | Load-counter instruction strobe |
| load_val | input | 8 | Value written to the counter on a load |
| test_stb | input | 1 | Skip-on-latch instruction strobe |
| skip_req | output | 1 | Request to skip the next instruction |
| idle_stb | input | 1 | Idle-until-overflow instruction strobe |
| halt | output | 1 | Stall for the rest of the core while idling |

## Verification
Several rules are checked by assertions on every cycle:
- skip_req never rises without an enabled, unhalted test.
- A wrap or a load with bit 7 set always leaves the latch set.
- A granted skip clears the latch unless a wrap lands in the same cycle.
- halt holds until a wrap and falls right after it.

The bench scenarios show what a per-cycle rule cannot. These include the exact number of cycles from a load to the wrap as seen at skip_req, and that strobes ignored during halt or with cyc_en low leave no trace in later behaviour. They also include a wake time set by the counter value from before the halt, and the collision of an idle strobe with a wrap.

// File: rtl/tbase_pkg.sv
// Package: shared definitions for the instruction-cycle time base.
// Assumes: the counter width is set by the top-level parameter.
package tbase_pkg;

    // Default counter width
    localparam int TB_CNT_W_DEF = 8;

    // Counter action selected in a cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_LOAD = 2'd2
    } cnt_act_t;

    // Qualified instruction strobes after enable and halt gating
    typedef struct packed {
        logic load;
        logic test;
        logic idle;
    } tb_cmd_t;

endpackage

// File: rtl/tbase_counter.sv
// Module: free-running time-base counter with a synchronous load.
// Does: advances by one per enabled cycle, or takes a loaded value instead,
//       and flags the cycle in which it steps from all ones to zero.
// Assumes: the load request is already qualified by the cycle enable.
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int CNT_W = TB_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_req,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_act_t act;

    // Choose the counter action: a load wins over an increment
    always_comb begin
        if (ld_req)
            act = CNT_LOAD;
        else if (tick)
            act = CNT_INC;
        else
            act = CNT_HOLD;
    end

    // A wrap happens only on a real increment from the top value
    assign wrap = (act == CNT_INC) && (cnt_q == CNT_MAX);

    // Counter register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else begin
            unique case (act)
                CNT_LOAD: cnt_q <= ld_val;
                CNT_INC:  cnt_q <= cnt_q + CNT_ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tbase_flag.sv
// Module: sticky overflow latch.
// Does: sets on a wrap or on a load with the top bit high. Clears on a
//       granted test request, but a set in the same cycle takes priority.
// Assumes: all inputs are single-cycle pulses already qualified upstream.
module tbase_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wrap,
    input  logic set_load,
    input  logic clr_req,
    output logic flag_q
);

    logic set_any;

    // Merge the two set sources
    assign set_any = set_wrap | set_load;

    // Latch update with set over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_any)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

endmodule

// File: rtl/tbase_idle.sv
// Module: idle controller.
// Does: raises halt after an idle request and drops it in the cycle after
//       the counter wraps. A wrap in the same cycle as the request wins.
// Assumes: enter is already gated by the enable and by halt itself.
module tbase_idle (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic wake,
    output logic halt_q
);

    // Halt state with wake priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (wake)
            halt_q <= 1'b0;
        else if (enter)
            halt_q <= 1'b1;
    end

endmodule

// File: rtl/tbase_timer.sv
// Module: top of the instruction-cycle time base.
// Does: qualifies the three instruction strobes with the cycle enable and
//       the halt state, then drives the counter, the latch and the idle
//       controller. The skip request is combinational in the test cycle.
// Assumes: strobes are valid only in cycles with cyc_en high.
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int CNT_W = TB_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             test_stb,
    output logic             skip_req,
    input  logic             idle_stb,
    output logic             halt
);

    localparam int MSB = CNT_W - 1;

    tb_cmd_t          cmd;
    logic             core_live;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             flag_q;
    logic             halt_q;

    // The core acts only in enabled cycles while it is not halted
    assign core_live = cyc_en & ~halt_q;

    // Qualify the instruction strobes
    always_comb begin
        cmd.load = core_live & load_stb;
        cmd.test = core_live & test_stb;
        cmd.idle = core_live & idle_stb;
    end

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cyc_en),
        .ld_req (cmd.load),
        .ld_val (load_val),
        .cnt_q  (cnt_q),
        .wrap   (wrap)
    );

    tbase_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wrap (wrap),
        .set_load (cmd.load & load_val[MSB]),
        .clr_req  (cmd.test),
        .flag_q   (flag_q)
    );

    tbase_idle u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .enter  (cmd.idle),
        .wake   (wrap),
        .halt_q (halt_q)
    );

    assign skip_req = cmd.test & flag_q;
    assign halt     = halt_q;

endmodule

// File: rtl/tbase_timer_chk.sv
// Module: property checker for tbase_timer, attached by bind.
// Does: watches the ports and the counter and latch state on every cycle.
// Assumes: the synchronous active-low reset disables every property.
module tbase_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic             test_stb,
    input logic             skip_req,
    input logic             idle_stb,
    input logic             halt,
    input logic [CNT_W-1:0] cnt,
    input logic             flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_wrap;
    logic live_load;

    // Conditions seen from outside the counter
    assign at_wrap   = cyc_en && !(load_stb && !halt) && (cnt == CNT_MAX);
    assign live_load = cyc_en && load_stb && !halt;

    // Skip requires an enabled, unhalted test
    assert_skip_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> (cyc_en && test_stb));

    // No skip while halted
    assert_no_skip_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !skip_req);

    // A wrap sets the latch and returns the counter to zero
    assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_wrap |=> (flag && cnt == '0));

    // A granted skip clears the latch when no wrap coincides
    assert_skip_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && !at_wrap) |=> !flag);

    // Wrap colliding with a clearing test keeps the latch set
    assert_collide_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && at_wrap) |=> flag);

    // A load with the top bit high sets the latch and takes the value
    assert_msb_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_load && load_val[CNT_W-1]) |=> (flag && cnt == $past(load_val)));

    // Idle raises halt unless a wrap coincides
    assert_idle_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && idle_stb && !halt && !at_wrap) |=> halt);

    // Halt holds until a wrap
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !at_wrap) |=> halt);

    // Halt drops in the cycle after a wrap
    assert_halt_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && at_wrap) |=> !halt);

    // Idle in the wrap cycle leaves halt low
    assert_idle_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && at_wrap) |=> !halt);

endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .load_stb (load_stb),
    .load_val (load_val),
    .test_stb (test_stb),
    .skip_req (skip_req),
    .idle_stb (idle_stb),
    .halt     (halt),
    .cnt      (cnt_q),
    .flag     (flag_q)
);

// File: tb/tbase_timer_tb.sv
`timescale 1ns/1ps
module tbase_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_en;
    logic       load_stb;
    logic [7:0] load_val;
    logic       test_stb;
    logic       idle_stb;
    logic       skip_req;
    logic       halt;

    int checks = 0;
    int errors = 0;

    // Reference state, derived from the requirements
    logic [7:0] m_cnt;
    logic       m_flag;
    logic       m_halt;

    always #2.5 clk = ~clk;

    tbase_timer #(.CNT_W(8)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .load_stb (load_stb),
        .load_val (load_val),
        .test_stb (test_stb),
        .skip_req (skip_req),
        .idle_stb (idle_stb),
        .halt     (halt)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against the reference, advance the reference
    task automatic step(input logic en, input logic ld, input logic [7:0] v,
                        input logic tst, input logic idl, input string req);
        logic live, wr, lset, clr;
        cyc_en = en; load_stb = ld; load_val = v; test_stb = tst; idle_stb = idl;
        #1;
        chk(req, "skip_req", skip_req, en & tst & m_flag & ~m_halt);
        chk(req, "halt", halt, m_halt);
        @(posedge clk);
        live = en & ~m_halt;
        wr   = en & ~(live & ld) & (m_cnt == 8'hFF);
        lset = live & ld & v[7];
        clr  = live & tst & m_flag;
        m_flag = (wr | lset) ? 1'b1 : (clr ? 1'b0 : m_flag);
        m_halt = wr ? 1'b0 : ((live & idl) ? 1'b1 : m_halt);
        m_cnt  = (live & ld) ? v : (en ? m_cnt + 8'd1 : m_cnt);
        #1;
    endtask

    task automatic idle_cycles(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cyc_en = 0; load_stb = 0; load_val = 0; test_stb = 0; idle_stb = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_cnt = 8'h00; m_flag = 1'b0; m_halt = 1'b0;
        chk("R1", "halt after reset", halt, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_count_wrap;
        // MSB-clear load keeps the latch clear (R6), then count with gaps (R2)
        step(1'b1, 1'b1, 8'h7C, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 140; i++)
            step(i % 3 != 0, 1'b0, 8'h00, 1'b0, 1'b0, "R2");
        idle_cycles(40, "R2");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_msb_load;
        step(1'b1, 1'b1, 8'h80, 1'b0, 1'b0, "R5");
        chk("R5", "latch set by load (explicit)", m_flag, 1'b1);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, 8'h10, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_collide;
        step(1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_gated;
        step(1'b0, 1'b1, 8'hF0, 1'b1, 1'b1, "R10");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R10");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R10");
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_idle;
        step(1'b1, 1'b1, 8'hE0, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R8");
        // Ignored strobes while halted
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R9");
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 8'h00, i == 10, 1'b0, "R8");
        chk("R8", "halt released (explicit)", halt, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_idle_at_wrap;
        step(1'b1, 1'b1, 8'h7E, 1'b0, 1'b0, "R11");
        idle_cycles(129, "R11");
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R11");
        chk("R11", "halt after idle at wrap (explicit)", halt, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R11");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_count_wrap();
        t_msb_load();
        t_collide();
        t_gated();
        t_idle();
        t_idle_at_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule